// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

After reset this block can copy a station address from an external serial EEPROM into the chip's byte-wide configuration registers. The EEPROM holds 64 words of 16 bits. The block reads it through a three-wire serial link: a serial clock, a chip select and one shared bidirectional data line. A strap level and three pin-ownership bits decide at start-up whether the load runs at all. When the load runs, the block reads words 0 to 6 in turn and writes words 1 to 3 into six byte registers as little-endian pairs. The other words are read and then dropped.

After the load, or after it is skipped, the host can reach the EEPROM through a pass-through port. This lets software read and write the words the loader leaves alone. Until the load finishes, the block blocks the host's register writes and its EEPROM requests. Each of the three pins can be handed to a general-purpose I/O function, one ownership bit per pin.

Top module: `ee_cfg_loader`

## Requirements
- R1: While reset is held, `busy_o` is 1 and `done_o` is 0. If `strap_ee_i` is low in the first clock after reset release, `busy_o` falls and `done_o` rises at that edge. No frame is sent and no pad output enable is ever raised.
- R2: If any bit of `pin_own_i` is 0 in that first clock, the load is skipped exactly as in R1.
- R3: A load sends seven frames, one for each of the word addresses 0 to 6 in rising order. In each frame `pad_o[2]` (chip select) is high and `pad_o[0]` (serial clock) pulses 26 times. The data line `pad_o[1]` carries, MSB first, a start bit 1, the opcode 10 and the 6-bit address over the first 9 rising edges. On rising edges 10 to 26 the block samples `dio_i`: a dummy bit, then 16 data bits MSB first.
- R4: For word k (k = 1, 2, 3) the block first writes the low byte to register 0x010+2(k-1) and then the high byte to the next address. Each write is a single-cycle `cfg_we_o` pulse. The loader makes exactly these six writes, in rising address order.
- R5: Between two frames, chip select stays low for at least one full serial-clock period. The serial clock is low whenever chip select rises, and it is high only while chip select is high.
- R6: The serial clock stays high for `sck_div_i`+1 system clock cycles in each pulse.
- R7: `busy_o` stays high until the last frame of the load has finished. Then `done_o` rises as `busy_o` falls, and `done_o` stays high until the next reset.
- R8: While `busy_o` is high, `host_reg_we_i` produces no write. Once the block is idle, a host register write appears on the `cfg_*` outputs in the same cycle.
- R9: While `busy_o` is high, `host_ee_req_i` is ignored. When the block is idle, a request with opcode 10 sends one read frame and then returns the word on `host_ee_rdata_o` with a one-cycle `host_ee_ack_o`.
- R10: A host frame with opcode 01 clocks the 16 bits of `host_ee_wdata_i` (MSB first) after the address, for 25 rising edges in all. Any other opcode that is not a read sends only the 9 command bits.
- R11: Pin index 0 is the serial clock, 1 is data and 2 is chip select. If `pin_own_i[i]` is 0, `pad_o[i]` and `pad_oe[i]` follow `gpio_o_i[i]` and `gpio_oe_i[i]`. If any ownership bit is 0 when a host request arrives, the request is acknowledged in the next cycle with data 0 and no frame is sent.
- R12: In a read frame the block stops driving the data line (`pad_oe[1]` low) from the ninth rising edge onward, so it never drives the line while the EEPROM does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_ee_i | input | 1 | EEPROM-present strap level |
| pin_own_i | input | 3 | Per-pin ownership, 1 = EEPROM, 0 = GPIO |
| sck_div_i | input | DIV_W | Serial clock half period minus one, in system cycles |
| dio_i | input | 1 | Level sensed on the data pad |
| pad_o | output | 3 | Pad output levels {cs, data, clock} |
| pad_oe | output | 3 | Pad output enables |
| gpio_o_i | input | 3 | GPIO output levels |
| gpio_oe_i | input | 3 | GPIO output enables |
| host_reg_we_i | input | 1 | Host configuration register write strobe |
| host_reg_addr_i | input | CFG_AW | Host register address |
| host_reg_data_i | input | 8 | Host register write data |
| cfg_we_o | output | 1 | Configuration register write strobe |
| cfg_addr_o | output | CFG_AW | Configuration register address |
| cfg_data_o | output | 8 | Configuration register write data |
| host_ee_req_i | input | 1 | Host EEPROM frame request |
| host_ee_op_i | input | 2 | Host frame opcode |
| host_ee_addr_i | input | 6 | Host frame word address |
| host_ee_wdata_i | input | 16 | Host frame write data |
| host_ee_ack_o | output | 1 | One-cycle completion pulse |
| host_ee_rdata_o | output | 16 | Word returned by a host read |
| busy_o | output | 1 | Power-up load in progress |
| done_o | output | 1 | Power-up phase over |

## Verification
Two kinds of traffic can meet in one cycle: the loader's writes into the address registers and host register writes, and the loader's frames and host pass-through requests. The bench holds a host register write to an unrelated address, and a host read request, high for the whole load. It then requires that the register log contains only the six loader bytes in order, that no acknowledge appears and that exactly seven frames occur. At the cycle where `busy_o` falls, a host write must show up on the outputs without delay.

// File: rtl/eel_pkg.sv
package eel_pkg;
   localparam int EE_AW      = 6;
   localparam int EE_DW      = 16;
   localparam int CMD_BITS   = 1 + 2 + EE_AW;
   localparam int FRAME_BITS = CMD_BITS + EE_DW;
   localparam int READ_RISES = CMD_BITS + 1 + EE_DW;
   localparam int NPINS      = 3;
   localparam int PIN_SCK    = 0;
   localparam int PIN_DIO    = 1;
   localparam int PIN_CS     = 2;

   typedef enum logic [1:0] {
      OP_MISC  = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_ERASE = 2'b11
   } ee_op_t;
endpackage

// File: rtl/eel_clkdiv.sv
module eel_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || tick)   cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/eel_frame.sv
module eel_frame
   import eel_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       op,
   input  logic [EE_AW-1:0] addr,
   input  logic [EE_DW-1:0] wdata,
   input  logic [DIV_W-1:0] div,
   input  logic             dio_in,
   output logic             sck,
   output logic             cs,
   output logic             dio_out,
   output logic             dio_oe,
   output logic             active,
   output logic             done,
   output logic [EE_DW-1:0] rdata
);
   localparam int RC_W  = $clog2(READ_RISES + 1);
   localparam int LOW_W = DIV_W + 3;

   typedef enum logic [1:0] {E_IDLE, E_SETUP, E_SHIFT, E_GAP} est_t;

   est_t                  st;
   logic [FRAME_BITS-1:0] osr;
   logic [EE_DW-1:0]      isr;
   logic [RC_W-1:0]       rise_cnt, last_rise;
   logic                  is_rd, gap_n, tick;

   eel_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(active), .div(div), .tick(tick)
   );

   assign active  = (st != E_IDLE);
   assign dio_out = osr[FRAME_BITS-1];
   assign dio_oe  = cs && (!is_rd || (rise_cnt < RC_W'(CMD_BITS)));
   assign rdata   = isr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= E_IDLE;
         osr       <= '0;
         isr       <= '0;
         rise_cnt  <= '0;
         last_rise <= '0;
         is_rd     <= 1'b0;
         gap_n     <= 1'b0;
         sck       <= 1'b0;
         cs        <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            E_IDLE: if (start) begin
               osr      <= {1'b1, op, addr, wdata};
               isr      <= '0;
               is_rd    <= (op == OP_READ);
               rise_cnt <= '0;
               if (op == OP_READ)       last_rise <= RC_W'(READ_RISES);
               else if (op == OP_WRITE) last_rise <= RC_W'(FRAME_BITS);
               else                     last_rise <= RC_W'(CMD_BITS);
               cs  <= 1'b1;
               sck <= 1'b0;
               st  <= E_SETUP;
            end
            E_SETUP: if (tick) st <= E_SHIFT;
            E_SHIFT: if (tick) begin
               if (!sck) begin
                  sck      <= 1'b1;
                  rise_cnt <= rise_cnt + 1'b1;
                  if (is_rd && rise_cnt >= RC_W'(CMD_BITS))
                     isr <= {isr[EE_DW-2:0], dio_in};
               end else begin
                  sck <= 1'b0;
                  if (rise_cnt == last_rise) begin
                     cs    <= 1'b0;
                     gap_n <= 1'b0;
                     st    <= E_GAP;
                  end else begin
                     osr <= osr << 1;
                  end
               end
            end
            E_GAP: if (tick) begin
               if (gap_n) begin
                  st   <= E_IDLE;
                  done <= 1'b1;
               end else begin
                  gap_n <= 1'b1;
               end
            end
            default: st <= E_IDLE;
         endcase
      end
   end

   // independent observer of chip-select low time
   logic [LOW_W-1:0] low_cyc;
   logic             seen_frame;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cyc    <= '0;
         seen_frame <= 1'b0;
      end else begin
         if (cs) begin
            low_cyc    <= '0;
            seen_frame <= 1'b1;
         end else if (low_cyc != '1) begin
            low_cyc <= low_cyc + 1'b1;
         end
      end
   end

   AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cs) && seen_frame) |-> ({3'b000, div} + 1'b1) <= (low_cyc >> 1)); // R5
   AST_CS_RISE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs) |-> !sck); // R5
   AST_SCK_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> cs); // R5
   AST_DONE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cs && !sck); // R3
endmodule

// File: rtl/eel_seq.sv
module eel_seq
   import eel_pkg::*;
#(
   parameter int              CFG_AW     = 10,
   parameter int              LOAD_WORDS = 7,
   parameter int              MAC_FIRST  = 1,
   parameter int              MAC_LAST   = 3,
   parameter logic [CFG_AW-1:0] MAC_BASE = 10'h010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap,
   input  logic              own_all,
   input  logic              host_req,
   input  logic [1:0]        host_op,
   input  logic [EE_AW-1:0]  host_addr,
   input  logic [EE_DW-1:0]  host_wdata,
   output logic              host_ack,
   output logic [EE_DW-1:0]  host_rdata,
   output logic              e_start,
   output logic [1:0]        e_op,
   output logic [EE_AW-1:0]  e_addr,
   output logic [EE_DW-1:0]  e_wdata,
   input  logic              e_done,
   input  logic [EE_DW-1:0]  e_rdata,
   output logic              ld_we,
   output logic [CFG_AW-1:0] ld_addr,
   output logic [7:0]        ld_data,
   output logic              busy,
   output logic              done
);
   localparam int MAC_BYTES = 2 * (MAC_LAST - MAC_FIRST + 1);

   if (MAC_LAST >= LOAD_WORDS || MAC_FIRST > MAC_LAST || LOAD_WORDS > (1 << EE_AW))
      begin : g_bad_window
         $error("eel_seq: address window parameters out of range");
      end

   typedef enum logic [2:0] {S_INIT, S_RD, S_WAIT, S_WLO, S_WHI, S_IDLE, S_HWAIT} sst_t;

   sst_t             st;
   logic [EE_AW-1:0] word;
   logic [EE_DW-1:0] dq;
   logic             in_mac, last_word;

   assign in_mac    = (word >= EE_AW'(MAC_FIRST)) && (word <= EE_AW'(MAC_LAST));
   assign last_word = (word == EE_AW'(LOAD_WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_INIT;
         word       <= '0;
         dq         <= '0;
         busy       <= 1'b1;
         done       <= 1'b0;
         host_ack   <= 1'b0;
         host_rdata <= '0;
         e_start    <= 1'b0;
         e_op       <= OP_READ;
         e_addr     <= '0;
         e_wdata    <= '0;
         ld_we      <= 1'b0;
         ld_addr    <= '0;
         ld_data    <= '0;
      end else begin
         e_start  <= 1'b0;
         ld_we    <= 1'b0;
         host_ack <= 1'b0;
         case (st)
            S_INIT: begin
               if (strap && own_all) begin
                  word <= '0;
                  st   <= S_RD;
               end else begin
                  busy <= 1'b0;
                  done <= 1'b1;
                  st   <= S_IDLE;
               end
            end
            S_RD: begin
               e_start <= 1'b1;
               e_op    <= OP_READ;
               e_addr  <= word;
               e_wdata <= '0;
               st      <= S_WAIT;
            end
            S_WAIT: if (e_done) begin
               dq <= e_rdata;
               if (in_mac) begin
                  st <= S_WLO;
               end else if (last_word) begin
                  busy <= 1'b0;
                  done <= 1'b1;
                  st   <= S_IDLE;
               end else begin
                  word <= word + 1'b1;
                  st   <= S_RD;
               end
            end
            S_WLO: begin
               ld_we   <= 1'b1;
               ld_addr <= MAC_BASE + CFG_AW'({word - EE_AW'(MAC_FIRST), 1'b0});
               ld_data <= dq[7:0];
               st      <= S_WHI;
            end
            S_WHI: begin
               ld_we   <= 1'b1;
               ld_addr <= ld_addr + 1'b1;
               ld_data <= dq[15:8];
               if (last_word) begin
                  busy <= 1'b0;
                  done <= 1'b1;
                  st   <= S_IDLE;
               end else begin
                  word <= word + 1'b1;
                  st   <= S_RD;
               end
            end
            S_IDLE: if (host_req) begin
               if (own_all) begin
                  e_start <= 1'b1;
                  e_op    <= host_op;
                  e_addr  <= host_addr;
                  e_wdata <= host_wdata;
                  st      <= S_HWAIT;
               end else begin
                  host_ack   <= 1'b1;
                  host_rdata <= '0;
               end
            end
            S_HWAIT: if (e_done) begin
               host_ack   <= 1'b1;
               host_rdata <= e_rdata;
               st         <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done); // R7
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R7
   AST_ACK_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack |-> !busy); // R9
   AST_LOAD_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ld_we |-> (ld_addr >= MAC_BASE) && (ld_addr < MAC_BASE + CFG_AW'(MAC_BYTES))); // R4
endmodule

// File: rtl/ee_cfg_loader.sv
module ee_cfg_loader
   import eel_pkg::*;
#(
   parameter int              DIV_W      = 8,
   parameter int              CFG_AW     = 10,
   parameter int              LOAD_WORDS = 7,
   parameter int              MAC_FIRST  = 1,
   parameter int              MAC_LAST   = 3,
   parameter logic [CFG_AW-1:0] MAC_BASE = 10'h010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_ee_i,
   input  logic [2:0]        pin_own_i,
   input  logic [DIV_W-1:0]  sck_div_i,
   input  logic              dio_i,
   output logic [2:0]        pad_o,
   output logic [2:0]        pad_oe,
   input  logic [2:0]        gpio_o_i,
   input  logic [2:0]        gpio_oe_i,
   input  logic              host_reg_we_i,
   input  logic [CFG_AW-1:0] host_reg_addr_i,
   input  logic [7:0]        host_reg_data_i,
   output logic              cfg_we_o,
   output logic [CFG_AW-1:0] cfg_addr_o,
   output logic [7:0]        cfg_data_o,
   input  logic              host_ee_req_i,
   input  logic [1:0]        host_ee_op_i,
   input  logic [5:0]        host_ee_addr_i,
   input  logic [15:0]       host_ee_wdata_i,
   output logic              host_ee_ack_o,
   output logic [15:0]       host_ee_rdata_o,
   output logic              busy_o,
   output logic              done_o
);
   localparam int MAC_BYTES = 2 * (MAC_LAST - MAC_FIRST + 1);

   if (DIV_W < 1 || CFG_AW < 8) begin : g_bad_width
      $error("ee_cfg_loader: DIV_W or CFG_AW too small");
   end

   logic             e_start, e_done, e_active;
   logic [1:0]       e_op;
   logic [EE_AW-1:0] e_addr;
   logic [EE_DW-1:0] e_wdata, e_rdata;
   logic             f_sck, f_cs, f_dio, f_dio_oe;
   logic             ld_we;
   logic [CFG_AW-1:0] ld_addr;
   logic [7:0]       ld_data;
   logic [NPINS-1:0] ee_o, ee_oe;

   eel_seq #(
      .CFG_AW(CFG_AW), .LOAD_WORDS(LOAD_WORDS), .MAC_FIRST(MAC_FIRST),
      .MAC_LAST(MAC_LAST), .MAC_BASE(MAC_BASE)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .strap(strap_ee_i), .own_all(&pin_own_i),
      .host_req(host_ee_req_i), .host_op(host_ee_op_i), .host_addr(host_ee_addr_i),
      .host_wdata(host_ee_wdata_i), .host_ack(host_ee_ack_o), .host_rdata(host_ee_rdata_o),
      .e_start(e_start), .e_op(e_op), .e_addr(e_addr), .e_wdata(e_wdata),
      .e_done(e_done), .e_rdata(e_rdata),
      .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
      .busy(busy_o), .done(done_o)
   );

   eel_frame #(.DIV_W(DIV_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .start(e_start), .op(e_op), .addr(e_addr),
      .wdata(e_wdata), .div(sck_div_i), .dio_in(dio_i),
      .sck(f_sck), .cs(f_cs), .dio_out(f_dio), .dio_oe(f_dio_oe),
      .active(e_active), .done(e_done), .rdata(e_rdata)
   );

   assign ee_o[PIN_SCK]  = f_sck;
   assign ee_o[PIN_DIO]  = f_dio;
   assign ee_o[PIN_CS]   = f_cs;
   assign ee_oe[PIN_SCK] = e_active;
   assign ee_oe[PIN_DIO] = f_dio_oe;
   assign ee_oe[PIN_CS]  = e_active;

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      assign pad_o[i]  = pin_own_i[i] ? ee_o[i]  : gpio_o_i[i];
      assign pad_oe[i] = pin_own_i[i] ? ee_oe[i] : gpio_oe_i[i];
   end

   assign cfg_we_o   = ld_we | (host_reg_we_i & ~busy_o);
   assign cfg_addr_o = ld_we ? ld_addr : host_reg_addr_i;
   assign cfg_data_o = ld_we ? ld_data : host_reg_data_i;

   AST_BUSY_WR_MAC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cfg_we_o) |-> (cfg_addr_o >= MAC_BASE) &&
                               (cfg_addr_o < MAC_BASE + CFG_AW'(MAC_BYTES))); // R8
   AST_FRAME_ONLY_BUSY_OR_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(e_active) |-> (busy_o || !done_o || &pin_own_i)); // R11
endmodule

// File: tb/ee_cfg_loader_tb.sv
module ee_cfg_loader_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap = 1'b0;
   logic [2:0]  own = 3'b111;
   logic [7:0]  div = 8'd1;
   logic [2:0]  pad_o, pad_oe;
   logic [2:0]  gpio_o = 3'b000, gpio_oe = 3'b000;
   logic        hr_we = 1'b0;
   logic [9:0]  hr_addr = '0;
   logic [7:0]  hr_data = '0;
   logic        cfg_we;
   logic [9:0]  cfg_addr;
   logic [7:0]  cfg_data;
   logic        he_req = 1'b0;
   logic [1:0]  he_op = 2'b10;
   logic [5:0]  he_addr = '0;
   logic [15:0] he_wdata = '0;
   logic        he_ack;
   logic [15:0] he_rdata;
   logic        busy, done;
   logic        dio_line;
   logic        log_clr = 1'b1;
   int          row_seed = 0;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   ee_cfg_loader u_dut (
      .clk(clk), .rst_n(rst_n), .strap_ee_i(strap), .pin_own_i(own), .sck_div_i(div),
      .dio_i(dio_line), .pad_o(pad_o), .pad_oe(pad_oe), .gpio_o_i(gpio_o), .gpio_oe_i(gpio_oe),
      .host_reg_we_i(hr_we), .host_reg_addr_i(hr_addr), .host_reg_data_i(hr_data),
      .cfg_we_o(cfg_we), .cfg_addr_o(cfg_addr), .cfg_data_o(cfg_data),
      .host_ee_req_i(he_req), .host_ee_op_i(he_op), .host_ee_addr_i(he_addr),
      .host_ee_wdata_i(he_wdata), .host_ee_ack_o(he_ack), .host_ee_rdata_o(he_rdata),
      .busy_o(busy), .done_o(done)
   );

   function automatic logic [15:0] gen(int w, int s);
      return 16'(w * 16'h0123) ^ 16'h5A00 ^ 16'(s << 4) ^ 16'(w << 11);
   endfunction

   // ---------------- EEPROM model ----------------
   logic [15:0] mem [64];
   logic        m_oe, m_bit;
   int          rc, nf;
   logic [8:0]  cmd;
   logic [15:0] sr;
   int          f_rc [16];
   int          f_addr [16];
   int          f_op [16];
   wire         m_sck = pad_o[0] & pad_oe[0];
   wire         m_cs  = pad_o[2] & pad_oe[2];

   assign dio_line = m_oe ? m_bit : pad_o[1];

   always @(posedge m_sck or negedge m_cs or posedge log_clr) begin
      if (log_clr) begin
         nf = 0; rc = 0; m_oe = 1'b0; m_bit = 1'b0; cmd = '0; sr = '0;
         for (int i = 0; i < 64; i++) mem[i] = gen(i, row_seed);
      end else if (!m_cs) begin
         if (rc > 0 && nf < 16) begin
            f_rc[nf] = rc; f_addr[nf] = int'(cmd[5:0]); f_op[nf] = int'(cmd[7:6]);
            nf++;
         end
         rc = 0; m_oe = 1'b0;
      end else begin
         rc++;
         if (rc <= 9) begin
            cmd = {cmd[7:0], pad_o[1]};
            if (rc == 9 && cmd[7:6] == 2'b10) begin
               sr = mem[cmd[5:0]];
               #1 m_oe = 1'b1; m_bit = 1'b0;
            end
         end else if (cmd[7:6] == 2'b10 && rc <= 25) begin
            #1 m_bit = sr[15];
            sr = sr << 1;
         end else if (cmd[7:6] == 2'b01 && rc <= 25) begin
            sr = {sr[14:0], pad_o[1]};
            if (rc == 25) mem[cmd[5:0]] = sr;
         end
      end
   end

   // ---------------- pin/port monitors ----------------
   int hi, last_hi, lo, min_gap, contention, ack_cnt, nw;
   logic seen_cs;
   logic [9:0] w_addr [32];
   logic [7:0] w_data [32];
   always @(posedge clk) begin
      if (log_clr) begin
         hi = 0; last_hi = 0; lo = 0; min_gap = 99999; seen_cs = 1'b0;
         contention = 0; ack_cnt = 0; nw = 0;
      end else begin
         if (m_sck) hi++;
         else if (hi > 0) begin last_hi = hi; hi = 0; end
         if (m_cs) begin
            if (seen_cs && lo > 0 && lo < min_gap) min_gap = lo;
            lo = 0; seen_cs = 1'b1;
         end else if (seen_cs) lo++;
         if (m_oe && pad_oe[1]) contention++;
         if (he_ack && busy) ack_cnt++;
         if (cfg_we && nw < 32) begin w_addr[nw] = cfg_addr; w_data[nw] = cfg_data; nw++; end
      end
   end

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic start_run(input logic s, input logic [2:0] o, input logic [7:0] d);
      @(negedge clk);
      rst_n = 1'b0; log_clr = 1'b1;
      strap = s; own = o; div = d;
      repeat (3) @(negedge clk);
      chk(busy === 1'b1 && done === 1'b0, "R1 reset state", {busy, done}, 2'b10);
      log_clr = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic host_frame(input logic [1:0] op, input logic [5:0] a,
                             input logic [15:0] wd, output logic [15:0] rd);
      int n;
      @(negedge clk);
      he_req = 1'b1; he_op = op; he_addr = a; he_wdata = wd;
      @(negedge clk);
      he_req = 1'b0;
      n = 0;
      while (!he_ack && n < 5000) begin @(negedge clk); n++; end
      chk(he_ack === 1'b1, "R9 host ack", he_ack, 1);
      rd = he_rdata;
      @(negedge clk);
   endtask

   // strap, owner bits, divider, load expected
   localparam logic [12:0] VEC [0:4] = '{
      {1'b0, 3'b111, 8'd1, 1'b0},
      {1'b1, 3'b111, 8'd0, 1'b1},
      {1'b1, 3'b011, 8'd1, 1'b0},
      {1'b1, 3'b110, 8'd2, 1'b0},
      {1'b1, 3'b111, 8'd1, 1'b1}
   };

   initial begin
      #(150000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] rd;
      int n, f0;
      for (int r = 0; r < 5; r++) begin
         logic        v_s;
         logic [2:0]  v_o;
         logic [7:0]  v_d;
         logic        v_l;
         {v_s, v_o, v_d, v_l} = VEC[r];
         row_seed = r;
         if (v_l) begin
            hr_we = 1'b1; hr_addr = 10'h200; hr_data = 8'hEE;
            he_req = 1'b1; he_op = 2'b10; he_addr = 6'd5;
         end
         start_run(v_s, v_o, v_d);
         if (!v_l) begin
            chk(done === 1'b1 && busy === 1'b0, v_s ? "R2 skip flags" : "R1 skip flags",
                {busy, done}, 2'b01);
            repeat (40) @(negedge clk);
            chk(nf == 0 && nw == 0, v_s ? "R2 no frames" : "R1 no frames", nf, 0);
            chk(pad_oe === 3'b000, "R1 pins undriven", pad_oe, 0);
            chk(done === 1'b1, "R7 done sticky", done, 1);
         end else begin
            chk(busy === 1'b1 && done === 1'b0, "R7 busy during load", {busy, done}, 2'b10);
            n = 0;
            while (!done && n < 20000) begin
               chk(!(busy && done), "R7 exclusive flags", {busy, done}, 2'b10);
               @(negedge clk); n++;
            end
            he_req = 1'b0; hr_we = 1'b0;
            chk(busy === 1'b0 && done === 1'b1, "R7 load finished", {busy, done}, 2'b01);
            chk(nf == 7, "R3 frame count", nf, 7);
            for (int k = 0; k < 7 && k < nf; k++) begin
               chk(f_addr[k] == k && f_op[k] == 2 && f_rc[k] == 26, "R3 frame content",
                   f_addr[k] * 256 + f_rc[k], k * 256 + 26);
            end
            chk(nw == 6, "R4 write count / R8 host write blocked", nw, 6);
            for (int j = 0; j < 6 && j < nw; j++) begin
               logic [15:0] wv;
               logic [7:0]  eb;
               wv = gen(1 + j / 2, r);
               eb = (j % 2 == 0) ? wv[7:0] : wv[15:8];
               chk(w_addr[j] == 10'h010 + 10'(j), "R4 write address", w_addr[j], 10'h010 + j);
               chk(w_data[j] == eb, "R4 write data", w_data[j], eb);
            end
            chk(ack_cnt == 0, "R9 no ack while busy", ack_cnt, 0);
            chk(last_hi == int'(v_d) + 1, "R6 clock high time", last_hi, int'(v_d) + 1);
            chk(min_gap >= 2 * (int'(v_d) + 1), "R5 chip select gap", min_gap, 2 * (int'(v_d) + 1));
            chk(contention == 0, "R12 data line released", contention, 0);
            @(negedge clk);
            hr_we = 1'b1; hr_addr = 10'h155; hr_data = 8'h3C;
            #0.5;
            chk(cfg_we === 1'b1 && cfg_addr === 10'h155 && cfg_data === 8'h3C,
                "R8 idle host write", {cfg_we, cfg_addr}, {1'b1, 10'h155});
            @(negedge clk);
            hr_we = 1'b0;
         end
      end

      // directed pass-through tests on the last loaded configuration
      f0 = nf;
      host_frame(2'b10, 6'h20, 16'h0, rd);
      chk(rd == gen(32, 4), "R9 host read data", rd, gen(32, 4));
      chk(nf == f0 + 1 && f_rc[f0] == 26, "R9 one read frame", f_rc[f0], 26);
      host_frame(2'b01, 6'h30, 16'hBEEF, rd);
      chk(f_rc[f0 + 1] == 25, "R10 write frame length", f_rc[f0 + 1], 25);
      chk(mem[6'h30] == 16'hBEEF, "R10 write data shifted", mem[6'h30], 16'hBEEF);
      host_frame(2'b00, 6'h30, 16'hFFFF, rd);
      chk(f_rc[f0 + 2] == 9, "R10 command-only frame", f_rc[f0 + 2], 9);
      host_frame(2'b10, 6'h30, 16'h0, rd);
      chk(rd == 16'hBEEF, "R9 read back written word", rd, 16'hBEEF);
      chk(contention == 0, "R12 no contention on host read", contention, 0);

      // GPIO ownership of the data pin
      @(negedge clk);
      own = 3'b101; gpio_o = 3'b010; gpio_oe = 3'b111;
      #0.5;
      chk(pad_o[1] === 1'b1 && pad_oe[1] === 1'b1, "R11 data pin to GPIO", {pad_o[1], pad_oe[1]}, 2'b11);
      chk(pad_oe[0] === 1'b0 && pad_oe[2] === 1'b0, "R11 owned pins idle", pad_oe, 3'b010);
      n = nf;
      @(negedge clk);
      he_req = 1'b1; he_op = 2'b10; he_addr = 6'h21;
      @(negedge clk);
      he_req = 1'b0;
      chk(he_ack === 1'b1 && he_rdata === 16'h0, "R11 not-owned ack zero", he_rdata, 0);
      repeat (10) @(negedge clk);
      chk(nf == n, "R11 no frame when not owned", nf, n);
      gpio_oe = 3'b000;
      #0.5;
      chk(pad_oe[1] === 1'b0, "R11 GPIO enable follows", pad_oe[1], 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule